// File: doc/BRIEF.md
# Packet Trailer Appender

This block sits in a byte-wide packet pipeline, after the stage that extracts a packet's total length and before the stage that computes the CRC. Each packet byte that arrives is written into a small byte FIFO. In the same cycle, a byte written earlier is read out, so the packet stream passes through the block with a short, fixed delay.

A controller marks the end of a packet with a one-cycle end-of-packet strobe. The block then stops taking input and drains the FIFO. Directly after the last packet byte it emits an 8-byte trailer with no idle cycle in between. When the final trailer byte is on the output, the block raises a one-cycle done pulse to the controller. After that it accepts the next packet.

The trailer carries these fields:
- a user-to-user byte taken from a configuration input;
- a common-part indicator byte, fixed at zero;
- the 16-bit total length, most significant byte first;
- four zero bytes that reserve room for the CRC added further down the pipeline.

Top module: `trailerAppender`

## Requirements
- R1: After reset and until the first byte is accepted, `outValid` and `doneTrailer` are 0.
- R2: While accepting, a byte presented with `inValid` at a rising edge appears on `outByte` with `outValid`=1 after the following rising edge. Bytes leave in arrival order, and the FIFO never overflows or underflows.
- R3: Trailer byte 0 appears on the cycle right after the last packet byte leaves, with no gap. For an empty packet, trailer byte 0 appears one edge after the end-of-packet edge. The eight trailer bytes are on consecutive cycles, and the FIFO is empty whenever a trailer byte is selected.
- R4: The trailer bytes, in output order, are:
  - byte 0: `uuByte`;
  - byte 1: 0x00;
  - byte 2: `totalLen[15:8]`;
  - byte 3: `totalLen[7:0]`;
  - bytes 4 to 7: 0x00.
- R5: `uuByte` and `totalLen` are captured at the edge where `eopIn` is sampled high while accepting. Later changes to them do not alter the trailer.
- R6: `doneTrailer` is high for exactly one cycle, on the same cycle as trailer byte 7, with `outValid`=1.
- R7: From the edge after end-of-packet through the edge that emits trailer byte 7, `inValid`, `inByte` and `eopIn` are ignored. None of those bytes ever reaches the output. The next packet byte is accepted at the edge after `doneTrailer`.
- R8: On any cycle that carries neither a packet byte nor a trailer byte, `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A packet byte is present on `inByte` |
| inByte | input | 8 | Packet byte from the length stage |
| eopIn | input | 1 | End-of-packet strobe from the controller |
| uuByte | input | 8 | User-to-user value placed in trailer byte 0 |
| totalLen | input | 16 | Packet total length placed in trailer bytes 2 and 3 |
| outValid | output | 1 | `outByte` carries a packet or trailer byte |
| outByte | output | 8 | Delayed packet stream with the trailer appended |
| doneTrailer | output | 1 | One-cycle pulse with the last trailer byte |

## Verification
The hardest situation to reach is the boundary between packets, for two reasons. First, the block must ignore garbage bytes and a stray end-of-packet strobe that arrive while it drains and sends the trailer. Second, the capture of `uuByte` and `totalLen` must hold even though both inputs change right after the strobe.

The stimulus covers packet lengths from 0 to 12 in three arrival patterns:
- back-to-back bytes, with the strobe on the last byte;
- alternate-cycle bytes;
- bytes followed by a late strobe.

Every cycle from the end-of-packet strobe through the done pulse carries junk input and changed field values. The next packet then follows, so any junk that leaked into the FIFO would show up in its output window.

// File: rtl/trailerPkg.sv
package trailerPkg;
  localparam int TRAIL_LEN = 8;
  localparam int IDX_W = $clog2(TRAIL_LEN);

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             selTrailer;
    logic [IDX_W-1:0] trailIdx;
    logic             latchFields;
  } ctrlStrb_t;
endpackage

// File: rtl/trailerDatapath.sv
module trailerDatapath
  import trailerPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [DW-1:0] inByte,
  input  logic [DW-1:0] uuByte,
  input  logic [15:0]   totalLen,
  output logic          fifoEmpty,
  output logic          outValid,
  output logic [DW-1:0] outByte
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [DW-1:0] CPI_VAL = '0;

  logic [DW-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [DW-1:0]  uuReg;
  logic [15:0]    lenReg;
  logic [DW-1:0]  trailArr [TRAIL_LEN];
  logic [DW-1:0]  trailByte;

  assign fifoEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.rdEn) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(strb.wrEn) - CNT_W'(strb.rdEn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uuReg  <= '0;
      lenReg <= '0;
    end else if (strb.latchFields) begin
      uuReg  <= uuByte;
      lenReg <= totalLen;
    end
  end

  always_comb begin
    for (int i = 0; i < TRAIL_LEN; i++) trailArr[i] = '0;
    trailArr[0] = uuReg;
    trailArr[1] = CPI_VAL;
    trailArr[2] = lenReg[15:8];
    trailArr[3] = lenReg[7:0];
    trailByte = trailArr[strb.trailIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
    end else if (strb.rdEn) begin
      outValid <= 1'b1;
      outByte  <= mem[rdPtr];
    end else if (strb.selTrailer) begin
      outValid <= 1'b1;
      outByte  <= trailByte;
    end else begin
      outValid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.rdEn) |-> (count < CNT_W'(DEPTH))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> (count != '0)); // R2
  AST_TRAIL_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    strb.selTrailer |-> (count == '0 && !strb.rdEn)); // R3
endmodule

// File: rtl/trailerControl.sv
module trailerControl
  import trailerPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      eopIn,
  input  logic      fifoEmpty,
  output ctrlStrb_t strb,
  output logic      doneTrailer
);
  typedef enum logic [1:0] {ACCEPT, DRAIN, TRAIL} state_t;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRAIL_LEN - 1);

  state_t state;
  logic [IDX_W-1:0] idx;

  always_comb begin
    strb.wrEn        = (state == ACCEPT) && inValid;
    strb.rdEn        = !fifoEmpty;
    strb.selTrailer  = ((state == DRAIN) && fifoEmpty) || (state == TRAIL);
    strb.trailIdx    = (state == TRAIL) ? idx : '0;
    strb.latchFields = (state == ACCEPT) && eopIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ACCEPT;
      idx         <= '0;
      doneTrailer <= 1'b0;
    end else begin
      doneTrailer <= 1'b0;
      case (state)
        ACCEPT: if (eopIn) state <= DRAIN;
        DRAIN: if (fifoEmpty) begin
          state <= TRAIL;
          idx   <= IDX_W'(1);
        end
        TRAIL: begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            state       <= ACCEPT;
            idx         <= '0;
            doneTrailer <= 1'b1;
          end
        end
        default: state <= ACCEPT;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneTrailer |=> !doneTrailer); // R6
  AST_DONE_REOPENS: assert property (@(posedge clk) disable iff (!rstN)
    doneTrailer |-> (state == ACCEPT)); // R7
endmodule

// File: rtl/trailerAppender.sv
module trailerAppender
  import trailerPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        eopIn,
  input  logic [7:0]  uuByte,
  input  logic [15:0] totalLen,
  output logic        outValid,
  output logic [7:0]  outByte,
  output logic        doneTrailer
);
  ctrlStrb_t strb;
  logic fifoEmpty;

  trailerControl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .eopIn(eopIn),
    .fifoEmpty(fifoEmpty), .strb(strb), .doneTrailer(doneTrailer)
  );

  trailerDatapath #(.DEPTH(DEPTH), .DW(8)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .uuByte(uuByte), .totalLen(totalLen), .fifoEmpty(fifoEmpty),
    .outValid(outValid), .outByte(outByte)
  );

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    doneTrailer |-> outValid); // R6
endmodule

// File: tb/trailerAppender_test.sv
module trailerAppender_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic eopIn = 1'b0;
  logic [7:0] uuByte = '0;
  logic [15:0] totalLen = '0;
  logic outValid;
  logic [7:0] outByte;
  logic doneTrailer;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  trailerAppender uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .eopIn(eopIn), .uuByte(uuByte), .totalLen(totalLen),
    .outValid(outValid), .outByte(outByte), .doneTrailer(doneTrailer)
  );

  logic       expV [64];
  logic [7:0] expB [64];
  logic       expD [64];
  string      expTag [64];

  task automatic checkCycle(input int c);
    nChecks++;
    if (outValid !== expV[c] || doneTrailer !== expD[c] ||
        (expV[c] && outByte !== expB[c])) begin
      nFails++;
      $display("FAIL %s cycle %0d: got v=%b b=%02h d=%b, expected v=%b b=%02h d=%b",
               expTag[c], c, outValid, outByte, doneTrailer,
               expV[c], expB[c], expD[c]);
    end
  endtask

  // mode 0: back-to-back, eop with last byte; 1: alternate cycles; 2: late eop
  task automatic runPacket(input int n, input int mode, input logic [7:0] uu,
                           input logic [15:0] len, input logic [7:0] seed);
    int edgeOf [16];
    int eopEdge, lastEdge, t0, win;
    logic [7:0] tb [8];
    for (int i = 0; i < n; i++) edgeOf[i] = (mode == 1) ? 2 * i : i;
    lastEdge = (n > 0) ? edgeOf[n-1] : -10;
    eopEdge = (n == 0) ? 0 : ((mode == 2) ? lastEdge + 2 : lastEdge);
    t0 = (eopEdge + 1 > lastEdge + 2) ? eopEdge + 1 : lastEdge + 2;
    win = t0 + 12;
    tb[0] = uu; tb[1] = 8'h00; tb[2] = len[15:8]; tb[3] = len[7:0];
    for (int k = 4; k < 8; k++) tb[k] = 8'h00;
    for (int c = 0; c < win; c++) begin
      expV[c] = 1'b0; expB[c] = '0; expD[c] = 1'b0; expTag[c] = "R8 idle";
    end
    for (int i = 0; i < n; i++) begin
      expV[edgeOf[i]+1] = 1'b1;
      expB[edgeOf[i]+1] = seed + 8'(i * 37);
      expTag[edgeOf[i]+1] = "R2 data";
    end
    for (int k = 0; k < 8; k++) begin
      expV[t0+k] = 1'b1; expB[t0+k] = tb[k];
      expTag[t0+k] = (k == 0) ? "R3 trailer start" : "R4 R5 trailer byte";
    end
    expD[t0+7] = 1'b1; expTag[t0+7] = "R6 done with byte 7";
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      if (c > 0) checkCycle(c - 1);
      inValid = 1'b0; inByte = 8'h00; eopIn = 1'b0;
      uuByte = uu; totalLen = len;
      for (int i = 0; i < n; i++)
        if (edgeOf[i] == c) begin inValid = 1'b1; inByte = seed + 8'(i * 37); end
      if (c == eopEdge) eopIn = 1'b1;
      if (c > eopEdge && c <= t0 + 7) begin
        // R7: junk input and stray strobe; R5: fields change after capture
        inValid = 1'b1; inByte = 8'hEE; eopIn = (c % 3 == 0);
        uuByte = ~uu; totalLen = ~len;
      end
    end
    @(negedge clk);
    checkCycle(win - 1);
    inValid = 1'b0; eopIn = 1'b0;
  endtask

  initial begin
    #(5 * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || doneTrailer !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: got v=%b d=%b, expected v=0 d=0", outValid, doneTrailer);
    end
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || doneTrailer !== 1'b0) begin
      nFails++;
      $display("FAIL R1 idle after reset: got v=%b d=%b, expected v=0 d=0",
               outValid, doneTrailer);
    end
    for (int mode = 0; mode < 3; mode++)
      for (int n = 0; n <= 12; n++)
        runPacket(n, mode, 8'(8'h5A + n * 11 + mode), 16'(16'h1234 + n * 257 + mode * 4099),
                  8'(n * 13 + mode * 71));
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule